// File: doc/BRIEF.md
# One-Time-Programmable Word ROM Bus Mode Responder

This block is a synthesizable, cycle-based stand-in for a 16-bit-wide one-time-programmable ROM. It is meant to sit on the far side of a device-programmer design under test. The model works at the level of control pins. Each clock it samples an active-low chip enable, an active-low output enable, and three flags: programming supply present, output-enable pin at high voltage, and address pin A9 at high voltage. From these it picks one bus mode. In that mode it either drives stored data, drives a fixed identifier, captures programming data, or stays off the bus. Analogue levels and nanosecond access delays are not modelled. Data appears a configurable number of clock edges after a driving mode begins.

The storage is a small array of `1 << ADDR_W` words and starts blank (all ones) at reset. Programming can only clear bits. Words are written in one of two ways. A single word can be written directly. Alternatively, four words are first loaded into page holding registers and then written in a single pulse. Page operation is selected by raising the output-enable high-voltage flag while the programming supply is present. It then stays selected until the supply is removed, which makes it a sticky mode.

The design has two state machines. The page-arming machine has states `ARM_OFF` and `ARM_ON`. It moves `ARM_OFF -> ARM_ON` on an edge where the programming supply and the output-enable high-voltage flag are both present. It moves `ARM_ON -> ARM_OFF` on an edge where the supply is absent. The output machine has states `OUT_IDLE`, `OUT_WAIT` and `OUT_DRIVE`:
- It moves `OUT_IDLE -> OUT_WAIT` on the first edge of a driving mode, or straight `OUT_IDLE -> OUT_DRIVE` when `READ_LAT` is 1.
- It moves `OUT_WAIT -> OUT_DRIVE` once `READ_LAT` edges of the driving mode have been counted.
- It moves `OUT_WAIT -> OUT_IDLE` and `OUT_DRIVE -> OUT_IDLE` on any edge that is not in a driving mode.

Top module: `otp_mode_responder`

## Requirements
- R1: With `ce_n`=1 and `vpp_hi`=0 (standby), `dout_en` is 0 and `dout` is 0 from the next clock edge on. After reset, `dout_en` is 0.
- R2: With `oe_n`=1, `dout_en` is 0 from the next clock edge, whatever the other inputs are. This covers output disable (`ce_n`=0, `vpp_hi`=0).
- R3: Read mode is `ce_n`=0, `oe_n`=0, `vpp_hi`=0, `a9_hv`=0. `dout_en` stays 0 for the first `READ_LAT`-1 edges of the mode and is 1 from edge `READ_LAT`. `dout` then shows the word at `addr`, following an address change one edge later.
- R4: Every word reads 16'hFFFF before it is programmed.
- R5: Word program is `vpp_hi`=1, page not armed, `ce_n`=0, `oe_n`=1. Only on the first low cycle of a `ce_n` pulse, word[`addr`] becomes word[`addr`] & `din`. Further low cycles of the same pulse change nothing.
- R6: Identifier mode is read mode with `a9_hv`=1. The bus drives 16'h0007 when `addr[0]`=0 and 16'h00A2 when `addr[0]`=1, for any other address bits.
- R7: On an edge with `vpp_hi`=1 and `oe_hv`=1, page mode arms. It stays armed while `vpp_hi`=1 and disarms on the first edge with `vpp_hi`=0. On that edge all four page holding registers return to 16'hFFFF, and afterwards a `ce_n` pulse with `oe_n`=1 is a word program again.
- R8: Page latch is `vpp_hi`=1 and `oe_hv`=1. On the first low cycle of a `ce_n` pulse, holding register `addr[1:0]` takes `din`.
- R9: Page program is page armed, `vpp_hi`=1, `oe_hv`=0, `oe_n`=1. On the first low cycle of a `ce_n` pulse, each word {`addr[ADDR_W-1:2]`, i} for i=0..3 becomes itself & holding register i. `din` is not written.
- R10: Verify is `vpp_hi`=1, `ce_n`=1, `oe_n`=0, `oe_hv`=0, armed or not. It drives the stored word at `addr` with the same latency as R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; array returns to blank |
| ce_n | input | 1 | Chip enable, active low; its falling cycle is the program/latch pulse |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming supply present |
| oe_hv | input | 1 | Output-enable pin at high voltage |
| a9_hv | input | 1 | Address pin A9 at high voltage (identifier select) |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Data presented for programming or latching |
| dout | output | DATA_W | Data driven on the bus; 0 when not enabled |
| dout_en | output | 1 | Bus drive enable; 0 models high impedance |

## Verification
A wrong arming state shows up as programming that lands in the wrong place. A pulse that should write a whole page instead clears a single word to `din`, or the reverse. This is seen at the next verify read, `READ_LAT` edges after verify begins. A wrong output-machine state shows as `dout_en` rising one edge early or late, or not dropping on the edge that samples `oe_n` high, so the bench samples `dout_en` on both sides of the latency boundary. Array or holding-register faults show as a mismatch against a bench model in which each word is the AND of every value applied to it. Exhaustive read sweeps of all words expose such faults within a single pass.

// File: rtl/otp_mode_pkg.sv
package otp_mode_pkg;

    typedef enum logic [3:0] {
        MD_STANDBY,
        MD_DISABLE,
        MD_READ,
        MD_IDENT,
        MD_VERIFY,
        MD_PG_LATCH,
        MD_PG_PROG,
        MD_WORD_PROG,
        MD_INHIBIT
    } bus_mode_e;

    typedef enum logic {
        ARM_OFF,
        ARM_ON
    } arm_state_e;

    typedef enum logic [1:0] {
        OUT_IDLE,
        OUT_WAIT,
        OUT_DRIVE
    } out_state_e;

    localparam int          PAGE_SEL_W = 2;
    localparam int          PAGE_WORDS = 1 << PAGE_SEL_W;
    localparam logic [7:0]  MFR_CODE   = 8'h07;
    localparam logic [7:0]  DEV_CODE   = 8'hA2;

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      vpp_hi,
    input  logic      oe_hv,
    input  logic      a9_hv,
    output bus_mode_e mode,
    output logic      armed,
    output logic      ce_fall
);

    arm_state_e arm_q, arm_d;
    logic       ce_prev_q;
    logic       armed_eff;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q     <= ARM_OFF;
            ce_prev_q <= 1'b1;
        end else begin
            arm_q     <= arm_d;
            ce_prev_q <= ce_n;
        end
    end

    // next state
    always_comb begin
        arm_d = arm_q;
        unique case (arm_q)
            ARM_OFF: if (vpp_hi && oe_hv) arm_d = ARM_ON;
            ARM_ON:  if (!vpp_hi)         arm_d = ARM_OFF;
            default: arm_d = ARM_OFF;
        endcase
    end

    // outputs
    always_comb begin
        armed     = (arm_q == ARM_ON);
        armed_eff = armed || (vpp_hi && oe_hv);
        ce_fall   = !ce_n && ce_prev_q;
        mode      = MD_INHIBIT;
        if (!vpp_hi) begin
            if (ce_n)       mode = MD_STANDBY;
            else if (oe_n)  mode = MD_DISABLE;
            else if (a9_hv) mode = MD_IDENT;
            else            mode = MD_READ;
        end else if (armed_eff) begin
            if (!ce_n && oe_hv)                mode = MD_PG_LATCH;
            else if (!ce_n && oe_n)            mode = MD_PG_PROG;
            else if (ce_n && !oe_n && !oe_hv)  mode = MD_VERIFY;
        end else begin
            if (!ce_n && oe_n)                 mode = MD_WORD_PROG;
            else if (ce_n && !oe_n)            mode = MD_VERIFY;
        end
    end

    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && vpp_hi) |=> armed);                          // R7
    AST_DISARM_ON_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_hi |=> !armed);                                   // R7
    AST_LATCH_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_PG_LATCH) |=> armed);                      // R8

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
    import otp_mode_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_mode_e         mode,
    input  logic              ce_fall,
    input  logic              vpp_hi,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic                         wr_word, wr_page, wr_latch;
    logic [DEPTH*DATA_W-1:0]      mem_flat;
    logic [PAGE_WORDS*DATA_W-1:0] latch_flat;

    assign wr_word  = ce_fall && (mode == MD_WORD_PROG);
    assign wr_page  = ce_fall && (mode == MD_PG_PROG);
    assign wr_latch = ce_fall && (mode == MD_PG_LATCH);

    for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_latch
        logic [DATA_W-1:0] lat_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lat_q <= '1;
            else if (wr_latch && (addr[PAGE_SEL_W-1:0] == PAGE_SEL_W'(i)))
                lat_q <= din;
            else if (!vpp_hi)
                lat_q <= '1;
        end
        assign latch_flat[i*DATA_W +: DATA_W] = lat_q;
    end

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(w);
        logic [DATA_W-1:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cell_q <= '1;
            else if (wr_word && (addr == WADDR))
                cell_q <= cell_q & din;
            else if (wr_page && (addr[ADDR_W-1:PAGE_SEL_W] == WADDR[ADDR_W-1:PAGE_SEL_W]))
                cell_q <= cell_q & latch_flat[(w % PAGE_WORDS)*DATA_W +: DATA_W];
        end
        assign mem_flat[w*DATA_W +: DATA_W] = cell_q;
    end

    assign rd_data = mem_flat[addr*DATA_W +: DATA_W];

    AST_SINGLE_SHOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word || wr_page || wr_latch) |=> !(wr_word || wr_page || wr_latch)); // R5

endmodule

// File: rtl/otp_out_fsm.sv
module otp_out_fsm
    import otp_mode_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int READ_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    localparam int CNT_W = $clog2(READ_LAT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(READ_LAT - 1);

    out_state_e        st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [DATA_W-1:0] data_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= OUT_IDLE;
            cnt_q  <= '0;
            data_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            data_q <= act ? data_in : '0;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            OUT_IDLE: begin
                cnt_d = CNT_W'(1);
                if (act) st_d = (READ_LAT == 1) ? OUT_DRIVE : OUT_WAIT;
            end
            OUT_WAIT: begin
                if (!act)                 st_d = OUT_IDLE;
                else if (cnt_q >= CNT_LAST) st_d = OUT_DRIVE;
                else                      cnt_d = cnt_q + CNT_W'(1);
            end
            OUT_DRIVE: if (!act) st_d = OUT_IDLE;
            default: st_d = OUT_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        dout_en = (st_q == OUT_DRIVE);
        dout    = dout_en ? data_q : '0;
    end

    AST_DRIVE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(act));                               // R3
    AST_QUIET_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));                            // R1

endmodule

// File: rtl/otp_mode_responder.sv
module otp_mode_responder
    import otp_mode_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 6,
    parameter int READ_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              oe_hv,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    bus_mode_e         mode;
    logic              armed, ce_fall, act;
    logic [DATA_W-1:0] rd_data, src_data;

    otp_mode_decode u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .vpp_hi  (vpp_hi),
        .oe_hv   (oe_hv),
        .a9_hv   (a9_hv),
        .mode    (mode),
        .armed   (armed),
        .ce_fall (ce_fall)
    );

    otp_cell_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .ce_fall (ce_fall),
        .vpp_hi  (vpp_hi),
        .addr    (addr),
        .din     (din),
        .rd_data (rd_data)
    );

    always_comb begin
        act      = (mode == MD_READ) || (mode == MD_IDENT) || (mode == MD_VERIFY);
        src_data = rd_data;
        if (mode == MD_IDENT)
            src_data = {{(DATA_W-8){1'b0}}, (addr[0] ? DEV_CODE : MFR_CODE)};
    end

    otp_out_fsm #(.DATA_W(DATA_W), .READ_LAT(READ_LAT)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .data_in (src_data),
        .dout    (dout),
        .dout_en (dout_en)
    );

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !vpp_hi) |=> !dout_en);                       // R1
    AST_OE_HIGH_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> !dout_en);                                    // R2
    AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && ($past(mode) == MD_IDENT)) |-> (dout[DATA_W-1:8] == '0)); // R6

endmodule

// File: tb/otp_mode_responder_tb.sv
`timescale 1ns/1ps
module otp_mode_responder_tb;

    localparam int DW  = 16;
    localparam int AW  = 6;
    localparam int LAT = 2;
    localparam int DEP = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, oe_hv = 1'b0, a9_hv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    logic [DW-1:0] ref_mem [DEP];
    logic [DW-1:0] ref_lat [4];
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    otp_mode_responder #(.DATA_W(DW), .ADDR_W(AW), .READ_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
        .oe_hv(oe_hv), .a9_hv(a9_hv), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic drive(input logic c, input logic o, input logic v, input logic h,
                         input logic a9, input logic [AW-1:0] a, input logic [DW-1:0] d);
        ce_n = c; oe_n = o; vpp_hi = v; oe_hv = h; a9_hv = a9; addr = a; din = d;
    endtask

    task automatic prog_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, a, d); tick(1);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, a, d); tick(1);
        ref_mem[a] &= d;
    endtask

    task automatic latch_word(input logic [1:0] i, input logic [DW-1:0] d);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, AW'(i), d); tick(1);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, AW'(i), d); tick(1);
        ref_lat[i] = d;
    endtask

    task automatic prog_page(input logic [AW-1:0] a);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, a, 16'h0000); tick(1);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, a, 16'h0000); tick(1);
        for (int i = 0; i < 4; i++) ref_mem[{a[AW-1:2], 2'(i)}] &= ref_lat[i];
    endtask

    task automatic verify_word(input string req, input logic [AW-1:0] a);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, a, 16'h0000); tick(LAT);
        check(req, {15'd0, dout_en, dout}, {15'd0, 1'b1, ref_mem[a]});
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, a, 16'h0000); tick(1);
    endtask

    task automatic disarm();
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0); tick(1);
        for (int i = 0; i < 4; i++) ref_lat[i] = 16'hFFFF;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEP; a++) ref_mem[a] = 16'hFFFF;
        for (int i = 0; i < 4; i++) ref_lat[i] = 16'hFFFF;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R1 reset", {15'd0, dout_en, dout}, 32'd0);

        // R3 latency boundary, R4 blank
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0, '0); tick(LAT - 1);
        check("R3 early", {31'd0, dout_en}, 32'd0);
        tick(1);
        check("R3 on time", {15'd0, dout_en, dout}, {15'd0, 1'b1, 16'hFFFF});
        for (int a = 0; a < DEP; a++) begin
            addr = AW'(a); tick(1);
            check("R4 blank", {16'd0, dout}, {16'd0, 16'hFFFF});
        end

        // R2 output disable, R1 standby
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd3, '0); tick(1);
        check("R2 disable", {15'd0, dout_en, dout}, 32'd0);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd3, '0); tick(LAT);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd3, '0); tick(1);
        check("R1 standby", {15'd0, dout_en, dout}, 32'd0);

        // R5 word program and R10 verify
        for (int a = 0; a < 32; a++) prog_word(AW'(a), 16'hFFFF ^ (16'(a + 1) << (a % 9)));
        for (int a = 0; a < 32; a++) verify_word("R10 verify word", AW'(a));
        for (int a = 0; a < 32; a++) prog_word(AW'(a), 16'hF0F0 | 16'(a * 37));
        for (int a = 0; a < 32; a++) verify_word("R5 and-accumulate", AW'(a));

        // R5 single shot: hold ce_n low and change din afterwards
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd40, 16'h7F3C); tick(1);
        din = 16'h0000; tick(2);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'd40, 16'h0000); tick(1);
        ref_mem[40] &= 16'h7F3C;
        verify_word("R5 single shot", 6'd40);
        verify_word("R5 neighbour untouched", 6'd41);

        // R8 latch, R9 page program on pages 8..15
        for (int p = 8; p < 16; p++) begin
            for (int i = 0; i < 4; i++) latch_word(2'(i), ~(16'(p) << (4 * i)) ^ 16'(i * 3));
            prog_page(AW'(p * 4 + 1));
            for (int i = 0; i < 4; i++) verify_word("R9 page word", AW'(p * 4 + i));
        end
        verify_word("R8 latch index", 6'd40);

        // R7 sticky: still armed, pulse with din=0 writes latches to page 2
        prog_page(6'd9);
        for (int i = 8; i < 12; i++) verify_word("R7 sticky page", AW'(i));

        // R7 disarm: word program works again, holding registers blank
        disarm();
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0); tick(1);
        prog_word(6'd44, 16'h00FF);
        verify_word("R7 word after disarm", 6'd44);
        verify_word("R7 word neighbour", 6'd45);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0, '0); tick(1);
        prog_page(6'd16);
        for (int i = 16; i < 20; i++) verify_word("R7 latches cleared", AW'(i));
        disarm();

        // R6 identifier
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'd0, '0); tick(LAT);
        check("R6 maker code", {15'd0, dout_en, dout}, {15'd0, 1'b1, 16'h0007});
        addr = 6'd1; tick(1);
        check("R6 part code", {16'd0, dout}, 32'h0000_00A2);
        addr = 6'd63; tick(1);
        check("R6 part code high addr", {16'd0, dout}, 32'h0000_00A2);
        addr = 6'd62; tick(1);
        check("R6 maker code high addr", {16'd0, dout}, 32'h0000_0007);

        // R3 read sweep of whole array
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0, '0); tick(LAT);
        for (int a = 0; a < DEP; a++) begin
            addr = AW'(a); tick(1);
            check("R3 read sweep", {15'd0, dout_en, dout}, {15'd0, 1'b1, ref_mem[a]});
        end
        oe_n = 1'b1; tick(1);
        check("R2 release", {31'd0, dout_en}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule